// File: doc/BRIEF.md
# Six-State Skip Counter

This block is a synchronous three-bit counter whose state bits are named A (most significant), B and C (least significant). It repeats a fixed cycle of six codes, 000 → 001 → 010 → 100 → 101 → 110 → 000, and never reaches 011 or 111 while it counts normally. Each bit is built as a JK flip-flop. A small equation stage works out the J and K inputs of each bit from the present state. A per-bit stage then applies the JK rule to form the next code.

The counter has no enable and no load. It advances on every rising clock edge unless reset is high. Its output is the state register itself, so the code appears one edge after the state it was computed from. If the register ever holds one of the two unused codes, the same equations bring it back into the cycle on the next edge.

Top module: `skipctr_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `q` becomes 000 after that edge, and it stays 000 for as long as `rst` stays high.
- R2: With `rst` low, each rising edge moves `q` to the successor of its present code: 000→001, 001→010, 010→100, 100→101, 101→110 and 110→000.
- R3: Starting from 000 with `rst` low, `q` returns to 000 after exactly six edges and does not show 000 at any edge in between.
- R4: Once reset is released from 000, `q` never shows 011 or 111 during normal counting.
- R5: If the register holds the unused code 011, the next edge with `rst` low loads 100.
- R6: If the register holds the unused code 111, the next edge with `rst` low loads 000.
- R7: Bit A (`q[2]`) follows J=K=B, so it inverts on an edge exactly when B was 1 before that edge.
- R8: Bit B (`q[1]`) follows J=C and K=1, so after an edge it is 1 only if C was 1 and B was 0 before that edge.
- R9: Bit C (`q[0]`) follows J=not B and K=1, so after an edge it is 1 only if both B and C were 0 before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| q | output | 3 | Registered state: bit 2 is A, bit 1 is B, bit 0 is C |

## Verification
The counter is walked from reset through two full six-code laps. This shows that every listed successor is reached, and that the cycle closes after six edges and not sooner or later. The two unused codes are planted one at a time in the state register. Because 011 and 111 lead to different places (100 and 000), these runs tell a correct set of JK equations apart from a shortcut that just clears any bad code. Reset is also applied in the middle of a lap, to show that it takes effect on the edge where it is high, whatever code is held.

// File: rtl/skipctr_pkg.sv
package skipctr_pkg;

  // Number of state bits: A (msb), B, C (lsb)
  localparam int CNT_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  // Bit positions inside the state word
  localparam int BIT_A = 2;
  localparam int BIT_B = 1;
  localparam int BIT_C = 0;

  localparam cnt_t CODE_ZERO = 3'b000;

  // JK rule: set on J, clear on K, hold on neither, invert on both
  function automatic logic jk_next(input logic j, input logic k, input logic q);
    return (j & ~q) | (~k & q);
  endfunction

  // Expected successor for the six-code cycle and for the unused codes
  function automatic cnt_t succ_code(input cnt_t s);
    cnt_t r;
    case (s)
      3'b000:  r = 3'b001;
      3'b001:  r = 3'b010;
      3'b010:  r = 3'b100;
      3'b100:  r = 3'b101;
      3'b101:  r = 3'b110;
      3'b110:  r = 3'b000;
      3'b011:  r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/skipctr_eq.sv
// Works out the J and K inputs of every state bit from the present code.
module skipctr_eq
  import skipctr_pkg::*;
(
  input  cnt_t state_i,
  output cnt_t j_o,
  output cnt_t k_o
);

  always_comb begin
    // A toggles on B
    j_o[BIT_A] = state_i[BIT_B];
    k_o[BIT_A] = state_i[BIT_B];
    // B sets from C, always clears otherwise
    j_o[BIT_B] = state_i[BIT_C];
    k_o[BIT_B] = 1'b1;
    // C sets when B is low, always clears otherwise
    j_o[BIT_C] = ~state_i[BIT_B];
    k_o[BIT_C] = 1'b1;
  end

endmodule

// File: rtl/skipctr_jk_bank.sv
// Applies the JK next-state rule to each bit of a word.
module skipctr_jk_bank #(
  parameter int W = 3
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  output logic [W-1:0] nxt_o
);

  import skipctr_pkg::jk_next;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign nxt_o[b] = jk_next(j_i[b], k_i[b], q_i[b]);
  end

endmodule

// File: rtl/skipctr_top.sv
module skipctr_top
  import skipctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] q
);

  cnt_t state_q;
  cnt_t j_w;
  cnt_t k_w;
  cnt_t nxt_w;

  skipctr_eq u_eq (
    .state_i (state_q),
    .j_o     (j_w),
    .k_o     (k_w)
  );

  skipctr_jk_bank #(.W(CNT_W)) u_bank (
    .q_i   (state_q),
    .j_i   (j_w),
    .k_i   (k_w),
    .nxt_o (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= CODE_ZERO;
    else     state_q <= nxt_w;
  end

  assign q = state_q;

endmodule

// File: rtl/skipctr_chk.sv
module skipctr_chk
  import skipctr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] q
);

  // R2: each legal code moves to its listed successor
  p_succ_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && q != 3'b011 && q != 3'b111) |=> (q == succ_code($past(q))));

  // R5: unused code 011 recovers to 100
  p_unused3_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && q == 3'b011) |=> (q == 3'b100));

  // R6: unused code 111 recovers to 000
  p_unused7_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && q == 3'b111) |=> (q == 3'b000));

  // R7: A inverts exactly when B was high
  p_bit_a_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (q[BIT_A] == ($past(q[BIT_A]) ^ $past(q[BIT_B]))));

  // R8: B high only after C high with B low
  p_bit_b_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (q[BIT_B] == ($past(q[BIT_C]) & ~$past(q[BIT_B]))));

  // R9: C high only after B and C both low
  p_bit_c_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (q[BIT_C] == (~$past(q[BIT_B]) & ~$past(q[BIT_C]))));

endmodule

bind skipctr_top skipctr_chk u_chk (
  .clk (clk),
  .rst (rst),
  .q   (q)
);

// File: tb/skipctr_top_tb.sv
`timescale 1ns/1ps
module skipctr_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  skipctr_top u_dut (
    .clk (clk),
    .rst (rst),
    .q   (q)
  );

  // Expected codes after each edge, walking two laps from 000
  localparam int NSTEP = 12;
  localparam logic [2:0] EXP_SEQ [0:NSTEP-1] = '{
    3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b000,
    3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b000
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset state, held over several edges
    step();
    step();
    check("R1", q, 3'b000);
    step();
    check("R1", q, 3'b000);

    // R2 R4 R7 R8 R9: walk two laps
    rst = 1'b0;
    for (int i = 0; i < NSTEP; i++) begin
      step();
      check("R2 R7 R8 R9", q, EXP_SEQ[i]);
      checks++;
      if (q == 3'b011 || q == 3'b111) begin
        errors++;
        $display("FAIL R4: q=%b expected a code other than 011/111", q);
      end
      // R3: zero only at the end of each six-edge lap
      if ((i % 6) != 5) begin
        checks++;
        if (q == 3'b000) begin
          errors++;
          $display("FAIL R3: q=%b expected nonzero at step %0d", q, i);
        end
      end else begin
        check("R3", q, 3'b000);
      end
    end

    // R1: reset in mid-lap (at code 100)
    step(); step(); step();
    check("R2", q, 3'b100);
    rst = 1'b1;
    step();
    check("R1", q, 3'b000);

    // R5: plant 011 while reset edge already passed
    force u_dut.state_q = 3'b011;
    rst = 1'b0;
    #0.5;
    release u_dut.state_q;
    check("R5 plant", q, 3'b011);
    step();
    check("R5", q, 3'b100);
    step();
    check("R2", q, 3'b101);

    // R6: plant 111
    rst = 1'b1;
    step();
    check("R1", q, 3'b000);
    force u_dut.state_q = 3'b111;
    rst = 1'b0;
    #0.5;
    release u_dut.state_q;
    check("R6 plant", q, 3'b111);
    step();
    check("R6", q, 3'b000);
    step();
    check("R2", q, 3'b001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule